// File: doc/BRIEF.md
# Dual-Protocol Host Register Port

This block is a slave on an external microprocessor bus. It serves a small file of eight-bit registers to the host. A static style input picks one of two bus protocols. The first uses a latch-enable pulse with separate active-low read and write strobes. The second uses an active-low address strobe, an active-low data strobe and one read/write level.

A second static input picks the bus form:
- Multiplexed: address and data share one bus.
- Demultiplexed: the address has its own pins.

In multiplexed form the upper bits of the address phase are compared with a fixed device-select value. This gives an internal chip-select decode, and the external chip select can then be tied low.

All host strobes are brought into the fast system clock through two-flop synchronizers. Edges are detected in the system clock domain. The address is captured on the falling edge of the latch enable or address strobe. A write commits once per strobe assertion. During a selected read the data bus is driven; at all other times it is released. One configuration bit (register 5, bit 4) is brought out to select dual-rail or single-rail transmit data.

The host must hold the address, and any write data, steady for at least three system clocks after the corresponding strobe edge.

Top module: `hbus_regport`

## Requirements
- R1: After reset every register reads 0x00, the bus is not driven (`dbus_oe` = 0) and `cfg_dual` is 0.
- R2: With `mode_ale` = 1, the address is taken on the falling edge of `ale_as`. A low on `wr_ds` writes the data bus to the addressed register. A low on `rd_rw` drives that register onto the bus.
- R3: With `mode_ale` = 0, the address is taken on the falling edge of `ale_as`, and `wr_ds` acts as data strobe. A low data strobe with `rd_rw` = 0 writes. A low data strobe with `rd_rw` = 1 reads.
- R4: Address inputs that change after the capturing falling edge do not affect which register a following write or read uses.
- R5: With `mux_en` = 1, the address comes from `dbus[4:0]` during the address phase. `dbus[7:5]` must equal 3'b101 (`DEV_SEL`), or the access neither writes nor drives the bus. With `mux_en` = 0, the address comes from `addr_in[4:0]` and no device-select compare is made.
- R6: While `cs_n` is high, a write strobe changes no register and a read strobe leaves `dbus_oe` at 0.
- R7: Registers exist at addresses 0 to 15. Addresses 16 to 31 read as 0x00, and writes to them are ignored.
- R8: One write strobe assertion commits exactly once. Data changed on the bus while the strobe is still held is not stored.
- R9: `cfg_dual` always equals bit 4 of register 5.
- R10: `dbus_oe` rises on the second system clock edge after a read strobe goes low. A write shows in `cfg_dual` on the third system clock edge after the write strobe goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ale | input | 1 | Static style: 1 latch-enable with read/write strobes, 0 address/data strobe |
| mux_en | input | 1 | Static form: 1 shared address/data bus, 0 separate address pins |
| ale_as | input | 1 | Latch enable (style 1) or active-low address strobe (style 0); falling edge captures address |
| rd_rw | input | 1 | Active-low read strobe (style 1) or read/write level (style 0) |
| wr_ds | input | 1 | Active-low write strobe (style 1) or active-low data strobe (style 0) |
| cs_n | input | 1 | Active-low chip select |
| addr_in | input | 5 | Address pins for demultiplexed form |
| dbus | inout | 8 | Data bus, also address bus in multiplexed form |
| dbus_oe | output | 1 | High while the block drives `dbus` |
| cfg_dual | output | 1 | Register 5 bit 4: dual-rail transmit data select |

## Verification
Every result sits behind the two synchronizer flops:
- The output enable follows a read strobe after two system clock edges.
- An address capture or a register write lands on the third edge.

The bench drives host pins on falling clock edges and samples on falling edges. It waits at least four clocks after each strobe change before checking or moving on, so every result is due before it is sampled. For the timing requirement it samples one edge early and exactly on the due edge. This confirms both the absence and the arrival of the output enable and of the configuration bit.

// File: rtl/hbus_regport.sv
module hbus_regport #(
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 8,
  parameter int unsigned NREG    = 16,
  parameter int unsigned DEV_SEL = 5,
  parameter int unsigned CFG_REG = 5,
  parameter int unsigned CFG_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ale,
  input  logic          mux_en,
  input  logic          ale_as,
  input  logic          rd_rw,
  input  logic          wr_ds,
  input  logic          cs_n,
  input  logic [AW-1:0] addr_in,
  inout  wire  [DW-1:0] dbus,
  output logic          dbus_oe,
  output logic          cfg_dual
);
  localparam int unsigned IW = $clog2(NREG);
  localparam int unsigned SW = DW - AW;

  logic [3:0] meta, sync;
  logic ale_q, wr_q;
  logic [AW-1:0] lat_addr;
  logic lat_hit;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] rd_data;
  logic [DW-1:0] bus_in;

  wire s_ale = sync[3];
  wire s_rd  = sync[2];
  wire s_wr  = sync[1];
  wire s_cs  = sync[0];

  assign bus_in = dbus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      sync <= '1;
    end else begin
      meta <= {ale_as, rd_rw, wr_ds, cs_n};
      sync <= meta;
    end
  end

  wire ale_fall = ale_q & ~s_ale;
  wire sel      = ~s_cs & lat_hit;
  wire rd_act   = mode_ale ? ~s_rd : (~s_wr & s_rd);
  wire wr_act   = mode_ale ? ~s_wr : (~s_wr & ~s_rd);
  wire wr_fire  = wr_act & ~wr_q & sel;
  wire impl     = 32'(lat_addr) < NREG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b1;
      wr_q     <= 1'b0;
      lat_addr <= '0;
      lat_hit  <= 1'b0;
    end else begin
      ale_q <= s_ale;
      wr_q  <= wr_act;
      if (ale_fall) begin
        lat_addr <= mux_en ? bus_in[AW-1:0] : addr_in;
        lat_hit  <= mux_en ? (32'(bus_in[DW-1:AW]) == DEV_SEL) : 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_fire && impl) begin
      regs[lat_addr[IW-1:0]] <= bus_in;
    end
  end

  assign rd_data  = impl ? regs[lat_addr[IW-1:0]] : '0;
  assign dbus_oe  = sel & rd_act;
  assign dbus     = dbus_oe ? rd_data : 'z;
  assign cfg_dual = regs[CFG_REG][CFG_BIT];

  // R8: a strobe assertion yields one commit only
  p_single_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  // R2: never drive the bus in a cycle that commits a write
  p_no_drive_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbus_oe && wr_fire));

  // R4: latched address moves only on a capturing edge
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(lat_addr));

  // R9: config bit changes only as the result of a write
  p_cfg_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_dual) |-> $past(wr_fire));

  // R7: unimplemented addresses read as zero
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && !impl) |-> (dbus == '0));

  // R6: no drive while deselected
  p_no_drive_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |-> !dbus_oe);
endmodule

// File: tb/hbus_regport_bench.sv
module hbus_regport_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic mode_ale = 1, mux_en = 0;
  logic ale_as = 1, rd_rw = 1, wr_ds = 1, cs_n = 1;
  logic [4:0] addr_in = '0;
  logic tb_drv = 0;
  logic [7:0] tb_val = '0;
  wire  [7:0] dbus;
  logic dbus_oe, cfg_dual;
  int checks = 0, errors = 0;
  bit done = 0;

  assign dbus = tb_drv ? tb_val : 'z;

  hbus_regport u_hbus_regport (
    .clk(clk), .rst_n(rst_n), .mode_ale(mode_ale), .mux_en(mux_en),
    .ale_as(ale_as), .rd_rw(rd_rw), .wr_ds(wr_ds), .cs_n(cs_n),
    .addr_in(addr_in), .dbus(dbus), .dbus_oe(dbus_oe), .cfg_dual(cfg_dual)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int c);
    return 8'((a * 37 + c * 91 + 5) & 255);
  endfunction

  function automatic logic [7:0] expect_after(input int a, input int c);
    return (a < 16) ? pat(a, c) : 8'h00;
  endfunction

  task automatic addr_phase(input logic [4:0] a, input logic [2:0] dev, input logic csn);
    @(negedge clk);
    cs_n = csn;
    addr_in = a;
    if (mux_en) begin tb_drv = 1; tb_val = {dev, a}; end
    ale_as = 1;
    wait_n(3);
    ale_as = 0;
    wait_n(4);
  endtask

  task automatic bus_idle();
    rd_rw = 1; wr_ds = 1;
    wait_n(4);
    cs_n = 1; tb_drv = 0; ale_as = 1;
    wait_n(2);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [2:0] dev,
                    input logic csn, input bit late_addr, input bit late_data);
    addr_phase(a, dev, csn);
    if (late_addr) addr_in = a ^ 5'd1;
    tb_drv = 1; tb_val = d;
    if (mode_ale) wr_ds = 0;
    else begin rd_rw = 0; wait_n(1); wr_ds = 0; end
    wait_n(5);
    if (late_data) begin tb_val = ~d; wait_n(5); end
    bus_idle();
  endtask

  task automatic rd(input logic [4:0] a, input logic [2:0] dev, input logic csn,
                    output logic [7:0] val, output logic oe);
    addr_phase(a, dev, csn);
    tb_drv = 0;
    if (mode_ale) rd_rw = 0;
    else begin rd_rw = 1; wr_ds = 0; end
    wait_n(4);
    oe = dbus_oe; val = dbus;
    bus_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    wait_n(3);
    chk(dbus_oe == 0, "R1 oe in reset", dbus_oe, 0);
    rst_n = 1;
    wait_n(2);
    chk(cfg_dual == 0, "R1 cfg_dual after reset", cfg_dual, 0);
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), 3'd5, 0, v, oe);
      chk(oe == 1 && v == 8'h00, "R1 reset contents", {oe, v}, 9'h100);
    end

    // Sweep all style/form combinations (R2, R3, R5, R7)
    for (int c = 0; c < 4; c++) begin
      mode_ale = c[1]; mux_en = c[0];
      wait_n(2);
      for (int a = 0; a < 32; a++) wr(5'(a), pat(a, c), 3'd5, 0, 0, 0);
      for (int a = 0; a < 32; a++) begin
        rd(5'(a), 3'd5, 0, v, oe);
        chk(oe == 1 && v == expect_after(a, c),
            mode_ale ? "R2 R7 latch-style readback" : "R3 R7 strobe-style readback",
            {oe, v}, {1'b1, expect_after(a, c)});
      end
      chk(cfg_dual == pat(5, c)[4], "R9 cfg_dual mirrors reg5 bit4", cfg_dual, pat(5, c)[4]);
    end

    // R5: wrong device select in multiplexed form
    mode_ale = 1; mux_en = 1;
    wr(5'd2, 8'h55, 3'd2, 0, 0, 0);
    rd(5'd2, 3'd2, 0, v, oe);
    chk(oe == 0, "R5 wrong device select no drive", oe, 0);
    rd(5'd2, 3'd5, 0, v, oe);
    chk(v == pat(2, 3), "R5 wrong device select no write", v, pat(2, 3));

    // R6: chip select high
    mux_en = 0;
    wr(5'd3, 8'hA5, 3'd5, 1, 0, 0);
    rd(5'd3, 3'd5, 1, v, oe);
    chk(oe == 0, "R6 deselected read no drive", oe, 0);
    rd(5'd3, 3'd5, 0, v, oe);
    chk(v == pat(3, 3), "R6 deselected write ignored", v, pat(3, 3));

    // R4: address pins change after capture
    wr(5'd6, 8'h3C, 3'd5, 0, 1, 0);
    rd(5'd6, 3'd5, 0, v, oe);
    chk(v == 8'h3C, "R4 late address change ignored (target)", v, 8'h3C);
    rd(5'd7, 3'd5, 0, v, oe);
    chk(v == pat(7, 3), "R4 late address change ignored (neighbour)", v, pat(7, 3));

    // R8: data changes while strobe held
    mode_ale = 0;
    wr(5'd9, 8'h81, 3'd5, 0, 0, 1);
    rd(5'd9, 3'd5, 0, v, oe);
    chk(v == 8'h81, "R8 single commit per strobe", v, 8'h81);

    // R10: latency of output enable and write
    mode_ale = 1;
    addr_phase(5'd5, 3'd5, 0);
    rd_rw = 0;
    wait_n(1);
    chk(dbus_oe == 0, "R10 oe not yet after one edge", dbus_oe, 0);
    wait_n(1);
    chk(dbus_oe == 1, "R10 oe after two edges", dbus_oe, 1);
    bus_idle();
    wr(5'd5, 8'h00, 3'd5, 0, 0, 0);
    chk(cfg_dual == 0, "R9 cfg_dual cleared", cfg_dual, 0);
    addr_phase(5'd5, 3'd5, 0);
    tb_drv = 1; tb_val = 8'h10;
    wr_ds = 0;
    wait_n(2);
    chk(cfg_dual == 0, "R10 write not yet after two edges", cfg_dual, 0);
    wait_n(1);
    chk(cfg_dual == 1, "R10 write after three edges", cfg_dual, 1);
    bus_idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule